// File: doc/BRIEF.md
# Pulse-Referenced Timebase Calibrator

This block derives a calibrated tick enable from a free-running raw oscillator. A calibration request arms the block. It then counts the gated oscillator ticks that occur while an external reference pulse is high. When the pulse falls, the count becomes the divisor for the output tick. The reference pulse is eight target periods long. An 8 µs pulse therefore trims the output to a nominal 1 MHz, and a 12 µs pulse trims it to about 667 kHz. The divisor keeps one fractional bit. A phase accumulator spreads that fraction over successive output ticks, so the long-run average period is exact.

Two configuration inputs shape the result. The rounding input picks one of two modes. In ceiling mode the divisor is rounded up, so the tick rate never exceeds the target. In centred mode it is rounded to the nearest value. The slow-oscillator input removes every third raw tick, which cuts the counting rate to two thirds. This lets a longer pulse fit in the 10-bit measurement counter. If the counter saturates during a pulse, a sticky fault is raised and the previous divisor stays in force.

The sequencer has three states. IDLE goes to ARM on a request. ARM goes to COUNT on a rising edge of the reference. COUNT goes back to IDLE in one of two ways. On the falling edge of the reference it loads the new divisor. On saturation of the counter it raises the fault.

Top module: `refcal_timebase`

## Requirements
- R1: After reset, busy, done and fault are low, and the divisor is 16 half-ticks, so one output tick is produced for every 8 gated ticks.
- R2: A request seen in IDLE makes busy high from the next cycle. Busy stays high until the divisor is loaded or the fault is raised, and then falls in the same cycle.
- R3: The count N is the number of gated ticks seen on clock edges where the reference is high, from the rising-edge cycle onward. In ceiling mode the divisor in half-ticks is D = floor((N+3)/4). After M gated ticks since a load, exactly floor(2M/D) output ticks have appeared, each one cycle after the gated tick that produced it.
- R4: In centred mode (rounding input at 1) the divisor is D = floor((N+2)/4).
- R5: The gated tick drops raw ticks number 3, 6, 9 and so on, counted from reset, whenever the slow input is 1. The same gated tick drives both the measurement and the tick output.
- R6: If the count reaches 1023 during a pulse, the fault is set and busy drops. No done pulse follows, and the earlier divisor keeps driving the ticks.
- R7: The fault stays high until the next accepted request. It is low from the cycle after that request.
- R8: During a calibration the previous divisor keeps driving the ticks. The new divisor replaces it in the cycle the reference is seen low, and the phase accumulator clears at the same edge.
- R9: A successful load gives a done pulse exactly one cycle long, and it coincides with busy falling.
- R10: A computed divisor below 2 half-ticks is raised to 2, which gives one output tick per gated tick.
- R11: A request that arrives while busy is ignored, and the calibration in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_tick | input | 1 | One-cycle enable for each raw oscillator period |
| slow_osc | input | 1 | 1 drops every third raw tick |
| center_mode | input | 1 | 0 selects ceiling rounding, 1 selects nearest rounding |
| cal_req | input | 1 | Calibration request, sampled in IDLE |
| ref_pulse | input | 1 | Reference pulse whose high time is measured |
| cal_tick | output | 1 | Calibrated tick enable |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle pulse when a new divisor is loaded |
| cal_fault | output | 1 | Sticky measurement overrun flag |

## Verification
A wrong count or a wrong rounding choice does not show until the divisor is used. It then appears as a tick total that drifts from floor(2M/D) within one or two divisor periods after the load. A phase counter in the gated-tick logic that is off by one changes both the measured count and the tick spacing, and it shows within three raw ticks of slow mode. A sequencer stuck in the wrong state shows on the next cycle as busy or done disagreeing with the reference edges. A fault that is lost or cleared early shows at once on the fault pin.

// File: rtl/refcal_pkg.sv
package refcal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } cal_state_e;

endpackage

// File: rtl/refcal_prescale.sv
module refcal_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_tick,
    input  logic slow_osc,
    output logic osc_tick
);
    logic [1:0] phase_q;

    // Phase advances on every raw tick, whatever the slow setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
        end else if (raw_tick) begin
            phase_q <= (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
        end
    end

    assign osc_tick = raw_tick && !(slow_osc && (phase_q == 2'd2));

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 2'd3); // R5

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_tick && phase_q == 2'd2) |=> (phase_q == 2'd0)); // R5
endmodule

// File: rtl/refcal_meas.sv
module refcal_meas
    import refcal_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             ref_pulse,
    input  logic             cal_req,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic             load,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

    cal_state_e       state_q, state_d;
    logic             ref_q;
    logic             ref_rise;
    logic             overrun;
    logic             start;
    logic [CNT_W-1:0] cnt_q;
    logic             fault_q;
    logic             done_q;

    assign ref_rise = ref_pulse && !ref_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cal_req) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (ref_rise) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!ref_pulse || overrun) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        busy    = (state_q != ST_IDLE);
        start   = (state_q == ST_IDLE) && cal_req;
        load    = (state_q == ST_COUNT) && !ref_pulse;
        overrun = (state_q == ST_COUNT) && ref_pulse && osc_tick
                  && (cnt_q == CNT_LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= 1'b0;
            cnt_q   <= '0;
            fault_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            ref_q  <= ref_pulse;
            done_q <= load;
            if ((state_q == ST_ARM) && ref_rise) begin
                cnt_q <= osc_tick ? CNT_W'(1) : '0;
            end else if ((state_q == ST_COUNT) && ref_pulse && osc_tick
                         && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (start) begin
                fault_q <= 1'b0;
            end else if (overrun) begin
                fault_q <= 1'b1;
            end
        end
    end

    assign count = cnt_q;
    assign fault = fault_q;
    assign done  = done_q;

    AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cal_req) |=> busy); // R2

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !start) |=> fault); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!fault && !busy)); // R6

    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cal_req && !load && !overrun) |=> busy); // R11
endmodule

// File: rtl/refcal_divcalc.sv
module refcal_divcalc #(
    parameter int CNT_W     = 10,
    parameter int REF_SHIFT = 3,
    parameter int FRAC_W    = 1
) (
    input  logic                              center_mode,
    input  logic [CNT_W-1:0]                  count,
    output logic [CNT_W+FRAC_W-REF_SHIFT:0]   div_out
);
    localparam int DROP  = REF_SHIFT - FRAC_W;
    localparam int DIV_W = CNT_W + 1 - DROP;
    localparam int SUM_W = CNT_W + 1;
    localparam logic [DIV_W-1:0] STEP = DIV_W'(1 << FRAC_W);

    logic [DIV_W-1:0] quo;

    generate
        if (DROP > 0) begin : g_round
            localparam logic [SUM_W-1:0] RND_UP  = SUM_W'((1 << DROP) - 1);
            localparam logic [SUM_W-1:0] RND_MID = SUM_W'(1 << (DROP - 1));
            logic [SUM_W-1:0] sum;
            always_comb begin
                sum = {1'b0, count} + (center_mode ? RND_MID : RND_UP);
                quo = DIV_W'(sum >> DROP);
            end
        end else begin : g_exact
            logic unused_mode;
            assign unused_mode = center_mode;
            assign quo = DIV_W'(count);
        end
    endgenerate

    assign div_out = (quo < STEP) ? STEP : quo;
endmodule

// File: rtl/refcal_tickgen.sv
module refcal_tickgen #(
    parameter int DIV_W     = 9,
    parameter int FRAC_W    = 1,
    parameter int RESET_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             load,
    input  logic [DIV_W-1:0] new_div,
    output logic             tick,
    output logic [DIV_W-1:0] div_cur
);
    localparam logic [DIV_W:0] STEP = (DIV_W+1)'(1 << FRAC_W);

    logic [DIV_W-1:0] acc_q;
    logic [DIV_W-1:0] div_q;
    logic             tick_q;
    logic [DIV_W:0]   sum_w;

    assign sum_w = {1'b0, acc_q} + STEP;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            div_q  <= DIV_W'(RESET_DIV);
            tick_q <= 1'b0;
        end else if (load) begin
            acc_q  <= '0;
            div_q  <= new_div;
            tick_q <= 1'b0;
        end else if (osc_tick) begin
            if (sum_w >= {1'b0, div_q}) begin
                acc_q  <= DIV_W'(sum_w - {1'b0, div_q});
                tick_q <= 1'b1;
            end else begin
                acc_q  <= DIV_W'(sum_w);
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick    = tick_q;
    assign div_cur = div_q;

    AST_ACC_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < div_q); // R3

    AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        div_q >= DIV_W'(1 << FRAC_W)); // R10

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_q == '0 && !tick_q)); // R8
endmodule

// File: rtl/refcal_timebase.sv
module refcal_timebase #(
    parameter int CNT_W     = 10,
    parameter int REF_SHIFT = 3,
    parameter int FRAC_W    = 1,
    parameter int RESET_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_tick,
    input  logic slow_osc,
    input  logic center_mode,
    input  logic cal_req,
    input  logic ref_pulse,
    output logic cal_tick,
    output logic cal_busy,
    output logic cal_done,
    output logic cal_fault
);
    localparam int DROP  = REF_SHIFT - FRAC_W;
    localparam int DIV_W = CNT_W + 1 - DROP;

    logic             osc_tick;
    logic             load;
    logic [CNT_W-1:0] count;
    logic [DIV_W-1:0] new_div;
    logic [DIV_W-1:0] div_cur;

    refcal_prescale u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_tick (raw_tick),
        .slow_osc (slow_osc),
        .osc_tick (osc_tick)
    );

    refcal_meas #(.CNT_W(CNT_W)) u_meas (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .ref_pulse (ref_pulse),
        .cal_req   (cal_req),
        .busy      (cal_busy),
        .done      (cal_done),
        .fault     (cal_fault),
        .load      (load),
        .count     (count)
    );

    refcal_divcalc #(
        .CNT_W     (CNT_W),
        .REF_SHIFT (REF_SHIFT),
        .FRAC_W    (FRAC_W)
    ) u_divcalc (
        .center_mode (center_mode),
        .count       (count),
        .div_out     (new_div)
    );

    refcal_tickgen #(
        .DIV_W     (DIV_W),
        .FRAC_W    (FRAC_W),
        .RESET_DIV (RESET_DIV)
    ) u_tickgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .load     (load),
        .new_div  (new_div),
        .tick     (cal_tick),
        .div_cur  (div_cur)
    );

    AST_DIV_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_cur) |-> cal_done); // R8
endmodule

// File: tb/refcal_timebase_bench.sv
module refcal_timebase_bench;
    logic clk = 1'b0;
    logic rst_n, raw_tick, slow_osc, center_mode, cal_req, ref_pulse;
    logic cal_tick, cal_busy, cal_done, cal_fault;

    always #2 clk = ~clk;

    refcal_timebase u_refcal_timebase (
        .clk(clk), .rst_n(rst_n), .raw_tick(raw_tick), .slow_osc(slow_osc),
        .center_mode(center_mode), .cal_req(cal_req), .ref_pulse(ref_pulse),
        .cal_tick(cal_tick), .cal_busy(cal_busy), .cal_done(cal_done),
        .cal_fault(cal_fault)
    );

    typedef struct { string tag; int val; } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    int raw_total = 0, g_load = 0, t_load = 0, d_cur = 16;
    bit last_g;
    logic s_busy, s_done, s_fault;

    task automatic push_exp(input string tag, input int v);
        exp_t e;
        e.tag = tag; e.val = v;
        exp_q.push_back(e);
    endtask

    // Monitor side: pop the oldest expectation and compare.
    task automatic observe(input int act);
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (act != e.val) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", e.tag, act, e.val);
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        push_exp(tag, exp);
        observe(act);
    endtask

    function automatic int exp_div(input int n, input bit ctr);
        int d;
        d = ctr ? (n + 2) / 4 : (n + 3) / 4;
        return (d < 2) ? 2 : d;
    endfunction

    // Sample the previous edge's results, then drive the next inputs.
    task automatic cyc(input logic raw, input logic refv, input logic req);
        @(negedge clk);
        s_busy = cal_busy; s_done = cal_done; s_fault = cal_fault;
        if (cal_tick) t_load++;
        raw_tick = raw; ref_pulse = refv; cal_req = req;
        last_g = 1'b0;
        if (raw) begin
            if (!(slow_osc && (raw_total % 3 == 2))) begin
                last_g = 1'b1;
                g_load++;
            end
            raw_total++;
        end
    endtask

    task automatic window(input int m, input string tag);
        for (int i = 0; i < m; i++) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        check(tag, t_load, (2 * g_load) / d_cur);
    endtask

    task automatic calib(input int h, input bit ctr, input int req_at);
        int g_cnt;
        bit flt;
        g_cnt = 0;
        center_mode = ctr;
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        check("R2 busy after request", s_busy, 1);
        check("R7 fault cleared by request", s_fault, 0);
        for (int i = 0; i < h; i++) begin
            cyc(1'b1, 1'b1, (i == req_at));
            if (last_g) g_cnt++;
        end
        cyc(1'b0, 1'b0, 1'b0);
        check("R8 old divisor ticks during measurement", t_load, (2 * g_load) / d_cur);
        flt = (g_cnt >= 1023);
        if (!flt) begin
            d_cur = exp_div(g_cnt, ctr);
            g_load = 0;
            t_load = 0;
        end
        cyc(1'b0, 1'b0, 1'b0);
        check("R9 done after load", s_done, !flt);
        check("R2 busy released", s_busy, 0);
        check("R6 fault state", s_fault, flt);
        cyc(1'b0, 1'b0, 1'b0);
        check("R9 done width", s_done, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; raw_tick = 1'b0; slow_osc = 1'b0; center_mode = 1'b0;
        cal_req = 1'b0; ref_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        check("R1 busy at reset", s_busy, 0);
        check("R1 done at reset", s_done, 0);
        check("R1 fault at reset", s_fault, 0);
        window(64, "R1 default divisor ticks");

        calib(41, 1'b0, -1);
        check("R3 ceiling divisor", d_cur, 11);
        window(55, "R3 ceiling tick count");

        calib(41, 1'b1, 20);
        check("R4 centred divisor", d_cur, 10);
        window(50, "R4 R11 centred ticks with ignored request");

        calib(1100, 1'b0, -1);
        window(40, "R6 earlier divisor kept after overrun");
        repeat (5) cyc(1'b0, 1'b0, 1'b0);
        check("R7 fault sticky while idle", s_fault, 1);

        slow_osc = 1'b1;
        calib(1100, 1'b0, -1);
        check("R5 slow count fits", s_fault, 0);
        window(61, "R5 slow tick count");

        slow_osc = 1'b0;
        calib(3, 1'b1, -1);
        check("R10 clamped divisor", d_cur, 2);
        window(10, "R10 one tick per gated tick");

        calib(40, 1'b1, -1);
        window(45, "R8 reload after clamp");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule